// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block keeps the interrupt state of a multi-channel DMA controller. Every channel owns one 32-bit control word. The word holds five per-source enable bits, five sticky status flags and five write-one-to-clear strobes. The five sources are fragment done, block done, transaction done, list done and configuration error. The transfer engines outside the block pulse one event line per source and channel. Software changes the enables and clears the flags through a simple write port, and reads any channel's word back through a combinational read port.

From the channel words the block forms two vectors with one bit per channel. The raw vector shows whether a channel has any status flag set. The masked vector shows whether a channel has any flag set whose enable is also set. Software scans the masked vector from the lowest channel upward to find the channels it must service. It expects at most one source flagged per channel and treats a mixture as an invalid type. A single interrupt line, registered, is raised while any masked bit is set.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous active-high reset, every enable and status bit is 0, both channel vectors are 0, and the interrupt output is 0.
- R2: An event pulse for source k of channel c (event bit c*5+k, sources ordered fragment=0, block=1, transaction=2, list=3, config-error=4) sets status bit 16+k of that channel's word at the next clock edge. This happens whether or not the source is enabled, and the flag stays set until it is cleared.
- R3: A write to channel c loads word bits 4:0 into that channel's enables (bit k enables source k). The new value reads back at the same positions after the clock edge.
- R4: In a write, a 1 at word bit 24+k clears status flag k of the addressed channel, and a 0 at that bit leaves the flag unchanged.
- R5: If an event pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R6: Raw vector bit c is 1 exactly when channel c has any status flag set.
- R7: Masked vector bit c is 1 exactly when channel c has some flag k set with enable k set.
- R8: The interrupt output equals the OR of the masked vector as it stood one clock cycle earlier.
- R9: Read data bits 31:21 and 15:5 always read 0, which includes the clear strobes at 28:24.
- R10: A write to one channel changes neither the enables nor the status of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NCH*5 | Event pulses, bit c*5+k is source k of channel c |
| wr_en | input | 1 | Write strobe for the addressed channel word |
| wr_chan | input | CW | Channel addressed by the write |
| wr_data | input | 32 | Write data: enables at 4:0, clear strobes at 28:24 |
| rd_chan | input | CW | Channel whose word appears on rd_data |
| rd_data | output | 32 | Read word: enables at 4:0, status at 20:16 |
| raw_vec | output | NCH | Per-channel any-status vector |
| msk_vec | output | NCH | Per-channel enabled-status vector |
| irq | output | 1 | Registered OR of the masked vector |

## Verification
The sweep runs over every channel and every source. Each is tried with three enable patterns: all sources off, only the firing source on, and every source except the firing one. This separates a status flag that depends on its enable from one that does not, and separates a masked bit that uses the matching enable from one that uses any enable. Clears are tried with the matching strobe, with no strobe, and together with a same-cycle event, which shows whether the set or the clear wins. Writes aimed at one channel while flags are pending on others expose address decoding that leaks to neighbouring channels.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int NSRC     = 5;
    localparam int WORD_W   = 32;
    localparam int EN_LSB   = 0;
    localparam int ST_LSB   = 16;
    localparam int CLR_LSB  = 24;

    typedef enum logic [2:0] {
        SRC_FRAG  = 3'd0,
        SRC_BLOCK = 3'd1,
        SRC_TRANS = 3'd2,
        SRC_LIST  = 3'd3,
        SRC_CFGER = 3'd4
    } irq_src_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t st;
        src_vec_t en;
    } chan_state_t;

    function automatic logic [WORD_W-1:0] pack_word(input chan_state_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_LSB +: NSRC] = s.en;
        w[ST_LSB +: NSRC] = s.st;
        return w;
    endfunction

    function automatic src_vec_t clear_field(input logic [WORD_W-1:0] d);
        return d[CLR_LSB +: NSRC];
    endfunction

    function automatic src_vec_t enable_field(input logic [WORD_W-1:0] d);
        return d[EN_LSB +: NSRC];
    endfunction

endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  src_vec_t          evt,
    output logic [WORD_W-1:0] word,
    output logic              raw,
    output logic              msk
);

    chan_state_t state_q;
    src_vec_t    clr;

    // Strobes apply only on a write to this channel.
    assign clr = wr_hit ? clear_field(wr_data) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            if (wr_hit) begin
                state_q.en <= enable_field(wr_data);
            end
            // Events are ORed in after the clear so that a pulse is never lost.
            state_q.st <= (state_q.st & ~clr) | evt;
        end
    end

    assign word = pack_word(state_q);
    assign raw  = |state_q.st;
    assign msk  = |(state_q.st & state_q.en);

endmodule

// File: rtl/dma_irq_out.sv
module dma_irq_out #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] msk_vec,
    output logic           irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |msk_vec;
        end
    end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import irqagg_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH*NSRC-1:0] evt,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_chan,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [CW-1:0]       rd_chan,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NCH-1:0]      raw_vec,
    output logic [NCH-1:0]      msk_vec,
    output logic                irq
);

    logic [WORD_W-1:0] words [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        assign hit = wr_en && (int'(wr_chan) == c);

        dma_irq_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit),
            .wr_data (wr_data),
            .evt     (evt[c*NSRC +: NSRC]),
            .word    (words[c]),
            .raw     (raw_vec[c]),
            .msk     (msk_vec[c])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(rd_chan) == c) begin
                rd_data = words[c];
            end
        end
    end

    dma_irq_out #(.NCH(NCH)) u_out (
        .clk     (clk),
        .rst     (rst),
        .msk_vec (msk_vec),
        .irq     (irq)
    );

endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk
    import irqagg_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [NCH*NSRC-1:0] evt,
    input logic                wr_en,
    input logic [CW-1:0]       wr_chan,
    input logic [WORD_W-1:0]   rd_data,
    input logic [NCH-1:0]      raw_vec,
    input logic [NCH-1:0]      msk_vec,
    input logic                irq
);

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        (|msk_vec) |=> irq);                                          // R8
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        !(|msk_vec) |=> !irq);                                        // R8
    AST_MSK_IN_RAW: assert property (@(posedge clk) disable iff (rst)
        (msk_vec & ~raw_vec) == '0);                                  // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:21] == '0 && rd_data[15:5] == '0);                 // R9

    for (genvar c = 0; c < NCH; c++) begin : g_ev
        AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
            (|evt[c*NSRC +: NSRC]) |=> raw_vec[c]);                   // R2
        AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (raw_vec[c] && !(wr_en && int'(wr_chan) == c)) |=> raw_vec[c]); // R10
    end

endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .wr_en   (wr_en),
    .wr_chan (wr_chan),
    .rd_data (rd_data),
    .raw_vec (raw_vec),
    .msk_vec (msk_vec),
    .irq     (irq)
);

// File: tb/dma_irq_agg_tb.sv
`timescale 1ns/100ps
module dma_irq_agg_tb;

    localparam int NCH = 4;
    localparam int NS  = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [NCH*NS-1:0] evt;
    logic          wr_en;
    logic [1:0]    wr_chan;
    logic [31:0]   wr_data;
    logic [1:0]    rd_chan;
    logic [31:0]   rd_data;
    logic [NCH-1:0] raw_vec;
    logic [NCH-1:0] msk_vec;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [4:0] m_en [NCH];
    logic [4:0] m_st [NCH];
    logic       m_irq;

    always #2.5 clk = ~clk;

    dma_irq_agg #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .evt(evt), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_data(wr_data), .rd_chan(rd_chan), .rd_data(rd_data),
        .raw_vec(raw_vec), .msk_vec(msk_vec), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [NCH-1:0] er, em;
        for (int c = 0; c < NCH; c++) begin
            er[c] = |m_st[c];
            em[c] = |(m_st[c] & m_en[c]);
            rd_chan = 2'(c);
            #0.1;
            chk(tag, rd_data, {11'b0, m_st[c], 11'b0, m_en[c]});
        end
        chk({tag, " R6 raw"}, 32'(raw_vec), 32'(er));
        chk({tag, " R7 msk"}, 32'(msk_vec), 32'(em));
        chk({tag, " R8 irq"}, 32'(irq), 32'(m_irq));
    endtask

    // One clock cycle: drive at the falling edge, update the model, check after the rising edge.
    task automatic cyc(input logic we, input int ch, input logic [31:0] d,
                       input logic [NCH*NS-1:0] ev);
        logic any;
        @(negedge clk);
        wr_en = we; wr_chan = 2'(ch); wr_data = d; evt = ev;
        any = 1'b0;
        for (int c = 0; c < NCH; c++) any |= |(m_st[c] & m_en[c]);
        m_irq = any;
        if (we) begin
            m_en[ch] = d[4:0];
            m_st[ch] = m_st[ch] & ~d[28:24];
        end
        for (int c = 0; c < NCH; c++) m_st[c] |= ev[c*NS +: NS];
        @(posedge clk);
        #0.5;
        wr_en = 0; evt = '0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; evt = '0; wr_en = 0; wr_chan = 0; wr_data = '0; rd_chan = 0;
        for (int c = 0; c < NCH; c++) begin m_en[c] = '0; m_st[c] = '0; end
        m_irq = 0;
        repeat (3) @(posedge clk);
        #0.5;
        check_all("R1 reset");
        @(negedge clk); rst = 0;
        @(posedge clk); #0.5;

        // Sweep: channel x source x enable pattern.
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NS; k++) begin
                for (int mode = 0; mode < 3; mode++) begin
                    logic [4:0] e;
                    logic [NCH*NS-1:0] ev;
                    e = (mode == 0) ? 5'd0 : (mode == 1) ? 5'(1 << k) : 5'(31 ^ (1 << k));
                    ev = '0; ev[c*NS + k] = 1'b1;
                    cyc(1, c, {24'b0, 3'b0, e}, '0);
                    check_all("R3 enable write");
                    cyc(0, 0, '0, ev);
                    check_all("R2 event set");
                    cyc(0, 0, '0, '0);
                    check_all("R8 irq follow");
                    cyc(1, c, {3'b0, 5'd0, 19'b0, e}, '0);
                    check_all("R4 zero clear no effect");
                    cyc(1, c, {3'b0, 5'(1 << k), 19'b0, e}, '0);
                    check_all("R4 clear");
                    cyc(0, 0, '0, '0);
                    check_all("R8 irq drop");
                end
            end
        end

        // Set wins over clear in the same cycle.
        cyc(1, 2, {32'h0000_001f}, '0);
        cyc(0, 0, '0, 20'h0_0400);
        check_all("R5 pre");
        cyc(1, 2, {3'b0, 5'b11111, 19'b0, 5'b11111}, 20'h0_0400);
        check_all("R5 set beats clear");

        // Isolation and reserved bits: flags on all channels, full-ones write to channel 1.
        cyc(0, 0, '0, 20'hFFFFF);
        check_all("R2 all set");
        cyc(1, 1, 32'hFFFF_FFFF, '0);
        check_all("R9 R10 ones write");
        cyc(1, 3, 32'h1F00_0000, '0);
        check_all("R10 clear ch3");

        rst = 1;
        @(negedge clk);
        @(posedge clk); #0.5;
        for (int c = 0; c < NCH; c++) begin m_en[c] = '0; m_st[c] = '0; end
        m_irq = 0;
        check_all("R1 reset again");
        finish_run();
    end

endmodule